// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two N-bit buses, called A and B, inside a synchronous design. Each direction of transfer has its own storage word, its own capture strobe, a source select and an output enable. A direction can either pass the word it sees on the far bus straight through (live) or present the word it last stored (held). Each bus port is split into an input, an output and an output-enable. A wrapper at the pad level can turn these into tri-state pins, so the block itself contains no internal tri-states.

All logic runs on one system clock with an active-low asynchronous reset. Each capture strobe is a level input, and a store happens on its low-to-high transition as sampled by the clock. The enables and selects do not gate the strobes, so either word can be loaded in any mode. A word is always stored from the resolved value of its bus: the block's own drive when that port is enabled, otherwise the external input. This lets a word that crosses from A to B be stored into the B-side word, and the reverse.

Each direction is a small state machine with three states. SRC_OFF means the port is not driven. SRC_LIVE means the port carries the far bus input from the previous clock. SRC_HELD means the port carries the stored word. At every clock a direction moves to SRC_OFF when its enable is inactive, to SRC_LIVE when the enable is active and the select is low, and to SRC_HELD when the enable is active and the select is high. These moves can happen from any state.

Top module: `dual_reg_xcvr`

## Requirements
- R1: After reset both stored words are zero, `a_oe` and `b_oe` are 0, and `a_out` and `b_out` are zero. A strobe that is already high when reset is released does not cause a store.
- R2: After each clock edge, `b_oe` equals the value `en_ab` had at that edge. `a_oe` equals the inverse of the value `en_ba_n` had at that edge (that enable is active low).
- R3: While `b_oe` is 1, `b_out` shows one of two values. If `sel_ab` was 0 at the last edge, it shows `a_in` as sampled at that edge (live). If `sel_ab` was 1, it shows the current A-side stored word (held).
- R4: While `a_oe` is 1, `a_out` shows one of two values. If `sel_ba` was 0 at the last edge, it shows `b_in` as sampled at that edge. If `sel_ba` was 1, it shows the current B-side stored word.
- R5: A port whose output-enable is 0 drives an all-zero word.
- R6: The A-side word is loaded at an edge where `cap_a` is 1, provided `cap_a` was 0 at the previous edge. The value loaded is the resolved A bus: `a_out` if `a_oe` is 1, otherwise `a_in`. In held mode, the new word appears on `b_out` right after that edge.
- R7: The B-side word is loaded in the same way, on a rise of `cap_b`, from the resolved B bus (`b_out` if `b_oe` is 1, otherwise `b_in`).
- R8: Neither stored word changes at any edge without a rise of its own strobe. Stores take place in every mode, including isolation, where both output-enables are 0.
- R9: A word can loop between buses. With `en_ab`=1 and `sel_ab`=0, a word on `a_in` appears on `b_out`, and a rise of `cap_b` then stores it in the B-side word.
- R10: With both directions enabled and both selects at 1, `b_out` shows the A-side word and `a_out` shows the B-side word at the same time.
- R11: With both directions enabled and both selects at 0, each output shows only the other port's external input from the previous edge. There is no combinational path from an output back to an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | External value on bus A |
| a_out | output | W | Word the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A, active high |
| b_in | input | W | External value on bus B |
| b_out | output | W | Word the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B, active high |
| cap_a | input | 1 | Store strobe for the A-side word (rising) |
| cap_b | input | 1 | Store strobe for the B-side word (rising) |
| en_ab | input | 1 | Enable for driving bus B, active high |
| en_ba_n | input | 1 | Enable for driving bus A, active low |
| sel_ab | input | 1 | B source: 0 live A input, 1 A-side word |
| sel_ba | input | 1 | A source: 0 live B input, 1 B-side word |

## Verification
The hardest case to reach is a store taken from the block's own drive rather than from the external input. To reach it, the port must be enabled and show a word that differs from its input, and the strobe must rise in the same cycle. The stimulus sets up a live crossing first, keeps the external input on the storing port at a different value, and then pulses the strobe. The stored word is then read back through the other direction in held mode. This covers both the A-to-B loopback and the mode where bus A is driven at the moment the A-side word is stored. Random enables, selects and strobe patterns follow, and a behavioural model compares all four outputs on every clock.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_LIVE = 2'd1,
        SRC_HELD = 2'd2
    } src_e;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // prev resets high so a strobe already high at reset release is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_in,
    input  logic [W-1:0] res_in,
    input  logic         cap,
    input  logic         en,
    input  logic         sel,
    output logic [W-1:0] dout,
    output logic         doe
);
    logic         rise;
    logic [W-1:0] store_q;
    logic [W-1:0] live_q;
    src_e         src_q;
    src_e         src_d;

    xcvr_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (cap),
        .rise (rise)
    );

    always_comb begin
        if (!en)     src_d = SRC_OFF;
        else if (sel) src_d = SRC_HELD;
        else         src_d = SRC_LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= SRC_OFF;
            store_q <= '0;
            live_q  <= '0;
        end else begin
            src_q  <= src_d;
            live_q <= ext_in;
            if (rise) store_q <= res_in;
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_LIVE: begin dout = live_q;  doe = 1'b1; end
            SRC_HELD: begin dout = store_q; doe = 1'b1; end
            default:  begin dout = '0;      doe = 1'b0; end
        endcase
    end

    AST_OE_ON:     assert property (@(posedge clk) disable iff (!rst_n) en |=> doe); // R2
    AST_OE_OFF:    assert property (@(posedge clk) disable iff (!rst_n) !en |=> !doe); // R2
    AST_LIVE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel) |=> (dout == $past(ext_in))); // R11
    AST_HELD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel) |=> (dout == store_q)); // R10
    AST_OFF_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
        !doe |-> (dout == '0)); // R5
    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(store_q)); // R8
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba
);
    logic [W-1:0] a_res;
    logic [W-1:0] b_res;

    // resolved bus values: own drive when enabled, else external input
    assign a_res = a_oe ? a_out : a_in;
    assign b_res = b_oe ? b_out : b_in;

    // A-side word, drives bus B
    xcvr_lane #(.W(W)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .ext_in(a_in),
        .res_in(a_res),
        .cap   (cap_a),
        .en    (en_ab),
        .sel   (sel_ab),
        .dout  (b_out),
        .doe   (b_oe)
    );

    // B-side word, drives bus A
    xcvr_lane #(.W(W)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .ext_in(b_in),
        .res_in(b_res),
        .cap   (cap_b),
        .en    (~en_ba_n),
        .sel   (sel_ba),
        .dout  (a_out),
        .doe   (a_oe)
    );

    AST_A_OE_POL: assert property (@(posedge clk) disable iff (!rst_n)
        en_ba_n |=> !a_oe); // R2
    AST_B_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ab && !sel_ab) |=> (b_out == $past(a_in))); // R3
    AST_A_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ba_n && !sel_ba) |=> (a_out == $past(b_in))); // R4
endmodule

// File: tb/test_dual_reg_xcvr.sv
module test_dual_reg_xcvr;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         cap_a = 1'b0, cap_b = 1'b0;
    logic         en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    dual_reg_xcvr #(.W(W)) i_dual_reg_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .cap_a(cap_a), .cap_b(cap_b),
        .en_ab(en_ab), .en_ba_n(en_ba_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba)
    );

    // behavioural reference
    int m_wa, m_wb, m_aout, m_bout, m_aoe, m_boe, m_pa, m_pb;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wa = 0; m_wb = 0; m_aout = 0; m_bout = 0;
            m_aoe = 0; m_boe = 0; m_pa = 1; m_pb = 1;
        end else begin
            int ra, rb, nwa, nwb;
            ra  = m_aoe ? m_aout : int'(a_in);
            rb  = m_boe ? m_bout : int'(b_in);
            nwa = (cap_a && !m_pa) ? ra : m_wa;
            nwb = (cap_b && !m_pb) ? rb : m_wb;
            m_pa = cap_a; m_pb = cap_b;
            m_wa = nwa; m_wb = nwb;
            m_boe = en_ab;
            m_bout = !en_ab ? 0 : (sel_ab ? nwa : int'(a_in));
            m_aoe = !en_ba_n;
            m_aout = en_ba_n ? 0 : (sel_ba ? nwb : int'(b_in));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2 b_oe", int'(b_oe), m_boe);
            chk("R2 a_oe", int'(a_oe), m_aoe);
            chk("R3 b_out", int'(b_out), m_bout);
            chk("R4 a_out", int'(a_out), m_aout);
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cap_a = 1'b1;                 // high through reset: no store (R1)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 a_oe", int'(a_oe), 0);
        chk("R1 b_oe", int'(b_oe), 0);
        chk("R1 a_out", int'(a_out), 0);
        chk("R1 b_out", int'(b_out), 0);
        a_in = 8'hEE; step();
        en_ab = 1; sel_ab = 1; step();
        chk("R1 no store on held strobe", int'(b_out), 0);
        cmp_on = 1'b1;

        // isolation store (R8), disabled zero (R5)
        cap_a = 0; en_ab = 0; en_ba_n = 1; a_in = 8'h5A; step();
        cap_a = 1; step();
        chk("R5 b_out off", int'(b_out), 0);
        cap_a = 0; step();
        en_ab = 1; sel_ab = 1; a_in = 8'h33; step();
        chk("R8 isolation store", int'(b_out), 8'h5A);
        step();
        chk("R8 hold", int'(b_out), 8'h5A);
        sel_ab = 0; step();
        chk("R3 live", int'(b_out), 8'h33);

        // loopback A -> B word (R9, R7)
        a_in = 8'hC3; b_in = 8'h11; step();
        chk("R9 crossing", int'(b_out), 8'hC3);
        cap_b = 1; step();
        cap_b = 0; en_ab = 0; en_ba_n = 0; sel_ba = 1; step();
        chk("R9 loopback store", int'(a_out), 8'hC3);

        // both held (R10)
        en_ab = 1; sel_ab = 1; step();
        chk("R10 b_out", int'(b_out), 8'h5A);
        chk("R10 a_out", int'(a_out), 8'hC3);

        // both live (R11)
        sel_ab = 0; sel_ba = 0; a_in = 8'h0F; b_in = 8'hF0; step();
        chk("R11 b_out", int'(b_out), 8'h0F);
        chk("R11 a_out", int'(a_out), 8'hF0);
        a_in = 8'h77; step();
        chk("R11 follows input", int'(b_out), 8'h77);

        // store from own drive on A (R6)
        en_ab = 0; b_in = 8'h99; step();
        a_in = 8'h00; cap_a = 1; step();
        cap_a = 0; en_ba_n = 1; en_ab = 1; sel_ab = 1; step();
        chk("R6 resolved store", int'(b_out), 8'h99);

        // held update right after store (R6)
        a_in = 8'h24; en_ab = 0; step();
        en_ab = 1; cap_a = 1; step();
        chk("R6 held shows new word", int'(b_out), 8'h24);
        cap_a = 0;

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            a_in = W'($urandom); b_in = W'($urandom);
            cap_a = r[0]; cap_b = r[1];
            en_ab = r[2]; en_ba_n = r[3];
            sel_ab = r[4]; sel_ba = r[5];
            step();
        end

        // reset mid-run (R1)
        rst_n = 0; #1;
        chk("R1 reset a_out", int'(a_out), 0);
        chk("R1 reset b_oe", int'(b_oe), 0);
        @(negedge clk); rst_n = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule